// File: doc/BRIEF.md
# TDM Frame Deserializer with Slot Holding Register

This block receives a time-division multiplexed serial stream that shares its bit clock with the sender. A frame is `SLOTS` timeslots of `SLOT_BITS` bits each, 256 bit times by default. The sender raises a frame marker during the last bit time of every frame. The receiver keeps a local bit counter and forces it into step with the sender whenever the marker is seen. The low counter bits give the bit position inside the current slot. The high bits give the slot number.

Incoming bits shift, least significant bit first, into a serial-in, parallel-out register. When the counter's bit field returns to zero and a whole byte has been assembled, the byte is copied into a holding register. The block then presents that byte with the number of the slot it came from and a one-clock valid strobe. The holding register stays unchanged for a full slot time, so downstream logic can read it while the next byte shifts in. `SLOT_BITS` and `SLOTS` must be powers of two.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is asserted, and after its release, `slot_byte`, `slot_num` and `slot_valid` are all zero until the first delivery.
- R2: No `slot_valid` pulse occurs before the first `ser_sync` has been observed, whatever is on `ser_data`.
- R3: A cycle with `ser_sync` high makes the local counter read 0 in the following cycle. Otherwise the counter advances by one every clock and wraps from 255 to 0. Counter bits [2:0] are the bit number and bits [7:3] are the slot number.
- R4: The bit received while the bit number is k becomes bit k of the delivered byte (LSB first).
- R5: A byte completed at bit number 7 is loaded into the holding register at the clock edge that ends the next bit-number-0 cycle. `slot_valid` is high in the cycle right after that edge.
- R6: `slot_num` on a valid pulse is the completed slot, which is the current slot field minus one, modulo 32. Slot 31 is therefore delivered during the first slot time of the next frame.
- R7: `slot_valid` is one clock wide and occurs at most once in any 8 consecutive clocks.
- R8: `slot_byte` and `slot_num` do not change in any cycle without a valid pulse.
- R9: A `ser_sync` that arrives when the local counter is not at 255 discards the byte in progress, even one whose last bit arrives in that same cycle. Reception restarts at slot 0.
- R10: In aligned operation every slot of every frame is delivered exactly once, in slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data, one bit per clock |
| ser_sync | input | 1 | Frame marker, high during the sender's last bit time of a frame |
| slot_byte | output | 8 | Held byte of the last completed slot |
| slot_num | output | 5 | Slot number of `slot_byte` |
| slot_valid | output | 1 | One-clock strobe when `slot_byte`/`slot_num` update |

## Verification
The bench streams five frames of different byte patterns and checks that every valid pulse lands at bit number 0 with the right slot number and byte. A design with the wrong bit order, an off-by-one slot number or a load at the wrong counter value would fail here. It drives data with no frame marker before lock, which catches a receiver that delivers garbage from an unaligned counter. It sends a misaligned marker exactly as a byte completes, where a receiver that keeps the byte would emit an extra slot 31. It also watches the held outputs in every idle cycle, which exposes a holding register that follows the moving shift register.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int DEF_SLOT_BITS = 8;
  localparam int DEF_SLOTS     = 32;

  typedef enum logic {
    RX_HUNT   = 1'b0,
    RX_LOCKED = 1'b1
  } rx_lock_e;
endpackage

// File: rtl/tdm_rx_counter.sv
module tdm_rx_counter
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  parameter int SLOTS     = DEF_SLOTS,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int CNT_W    = BIT_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              locked_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic              byte_end_o,
  output logic              slot_start_o,
  output logic              aligned_sync_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [BIT_W-1:0] BIT_LAST = {BIT_W{1'b1}};

  function automatic logic [BIT_W-1:0] bit_of(input logic [CNT_W-1:0] c);
    return c[BIT_W-1:0];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [CNT_W-1:0] c);
    return c[CNT_W-1:BIT_W];
  endfunction

  logic [CNT_W-1:0] cnt_q;
  rx_lock_e         lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= RX_HUNT;
    end else if (sync_i) begin
      cnt_q  <= '0;
      lock_q <= RX_LOCKED;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o          = cnt_q;
  assign locked_o       = (lock_q == RX_LOCKED);
  assign bit_idx_o      = bit_of(cnt_q);
  assign slot_idx_o     = slot_of(cnt_q);
  assign byte_end_o     = (bit_of(cnt_q) == BIT_LAST);
  assign slot_start_o   = (bit_of(cnt_q) == '0);
  assign aligned_sync_o = sync_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/tdm_rx_sipo.sv
module tdm_rx_sipo #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  // LSB first: the newest bit enters at the top and older bits move down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {din, sr_q[W-1:1]};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/tdm_rx_hold.sv
module tdm_rx_hold #(
  parameter int W      = 8,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [W-1:0]      word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [W-1:0]      byte_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o  <= '0;
      slot_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        byte_o <= word_i;
        slot_o <= slot_i;
      end
    end
  end
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  parameter int SLOTS     = DEF_SLOTS,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int CNT_W    = BIT_W + SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_data,
  input  logic                 ser_sync,
  output logic [SLOT_BITS-1:0] slot_byte,
  output logic [SLOT_W-1:0]    slot_num,
  output logic                 slot_valid
);
  // The slot that finished one slot time before the current one.
  function automatic logic [SLOT_W-1:0] prev_slot(input logic [SLOT_W-1:0] s);
    return s - SLOT_W'(1);
  endfunction

  logic [CNT_W-1:0]     frame_cnt;
  logic                 rx_locked;
  logic [BIT_W-1:0]     bit_idx;
  logic [SLOT_W-1:0]    slot_idx;
  logic                 byte_end;
  logic                 slot_start;
  logic                 aligned_sync;
  logic [SLOT_BITS-1:0] sr_word;
  logic                 have_byte_q;
  logic                 load_evt;

  tdm_rx_counter #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_cnt (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_i         (ser_sync),
    .cnt_o          (frame_cnt),
    .locked_o       (rx_locked),
    .bit_idx_o      (bit_idx),
    .slot_idx_o     (slot_idx),
    .byte_end_o     (byte_end),
    .slot_start_o   (slot_start),
    .aligned_sync_o (aligned_sync)
  );

  tdm_rx_sipo #(.W(SLOT_BITS)) u_sipo (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (ser_data),
    .word_o (sr_word)
  );

  // A byte counts as complete only when its last bit arrived on an aligned
  // counter; a frame marker at any other count drops the partial byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      have_byte_q <= 1'b0;
    else if (ser_sync)               have_byte_q <= rx_locked && aligned_sync;
    else if (byte_end && rx_locked)  have_byte_q <= 1'b1;
    else if (slot_start)             have_byte_q <= 1'b0;
  end

  assign load_evt = slot_start && have_byte_q;

  tdm_rx_hold #(.W(SLOT_BITS), .SLOT_W(SLOT_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_evt),
    .word_i  (sr_word),
    .slot_i  (prev_slot(slot_idx)),
    .byte_o  (slot_byte),
    .slot_o  (slot_num),
    .valid_o (slot_valid)
  );

  logic unused_bits;
  assign unused_bits = ^bit_idx;
endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
  parameter int W      = 8,
  parameter int SLOT_W = 5,
  parameter int BIT_W  = 3,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic [CNT_W-1:0]  cnt,
  input logic              locked,
  input logic              load_evt,
  input logic              slot_valid,
  input logic [W-1:0]      slot_byte,
  input logic [SLOT_W-1:0] slot_num
);
  a_r3_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> cnt == '0);

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> cnt == CNT_W'($past(cnt) + 1));

  a_r2_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !slot_valid);

  a_r5_load_at_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> cnt[BIT_W-1:0] == '0);

  a_r5_valid_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> $past(load_evt));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |=> !slot_valid);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |-> ($stable(slot_byte) && $stable(slot_num)));

  a_r9_misalign_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && cnt != '1) |=> !load_evt);
endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(
  .W(SLOT_BITS), .SLOT_W(SLOT_W), .BIT_W(BIT_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_i     (ser_sync),
  .cnt        (frame_cnt),
  .locked     (rx_locked),
  .load_evt   (load_evt),
  .slot_valid (slot_valid),
  .slot_byte  (slot_byte),
  .slot_num   (slot_num)
);

// File: tb/test_tdm_frame_rx.sv
`timescale 1ns/1ps
module test_tdm_frame_rx;
  localparam int NFR = 5;
  // Per-frame pattern: byte of slot s = base + s*step.
  localparam logic [15:0] VEC [NFR] = '{16'h0000, 16'hFF00, 16'h0107, 16'hA53C, 16'h5A11};

  logic clk = 0, rst_n = 0, ser_data = 0, ser_sync = 0;
  logic [7:0] slot_byte;
  logic [4:0] slot_num;
  logic slot_valid;

  int errors = 0, checks = 0;
  int pos = 0;
  bit mon_en = 0;
  int vcount = 0;
  int exp_slot = 0, exp_fr = 0;
  logic [7:0] last_byte = 0;
  logic [4:0] last_num = 0;
  int last_vpos = -100, tick = 0;

  tdm_frame_rx i_tdm_frame_rx (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_sync(ser_sync),
    .slot_byte(slot_byte), .slot_num(slot_num), .slot_valid(slot_valid)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int f, input int s);
    return VEC[f][15:8] + 8'(s) * VEC[f][7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic s, input int p);
    @(negedge clk);
    ser_data = d; ser_sync = s; pos = p;
  endtask

  task automatic send_frame(input int f);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] b;
      b = pat(f, c >> 3);
      drive(b[c & 7], c == 255, c);
    end
  endtask

  // Monitor: sample just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      tick++;
      if (slot_valid) begin
        vcount++;
        chk(tick - last_vpos >= 8, "R7 pulse spacing", tick - last_vpos, 8);
        last_vpos = tick;
        if (mon_en) begin
          chk((pos & 7) == 0, "R3/R5 valid timing bit number", pos & 7, 0);
          chk(slot_num == 5'(exp_slot), "R6/R10 slot number", slot_num, exp_slot);
          chk(slot_byte == pat(exp_fr, exp_slot), "R4/R10 slot byte", slot_byte, pat(exp_fr, exp_slot));
          exp_slot++;
          if (exp_slot == 32) begin exp_slot = 0; exp_fr++; end
        end
        last_byte = slot_byte; last_num = slot_num;
      end else begin
        chk(slot_byte == last_byte && slot_num == last_num, "R8 held outputs stable",
            {slot_num, slot_byte}, {last_num, last_byte});
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(slot_byte == 0 && slot_num == 0 && slot_valid == 0, "R1 reset state",
        {slot_valid, slot_num, slot_byte}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(slot_valid == 0 && slot_byte == 0, "R1 after release", {slot_valid, slot_byte}, 0);

    // Pre-lock: data without frame marker.
    for (int i = 0; i < 40; i++) drive(logic'((i * 7 + 3) % 3 == 0), 1'b0, i);
    chk(vcount == 0, "R2 no delivery before lock", vcount, 0);

    // Align, then stream frames walked from the table.
    drive(1'b0, 1'b1, 255);
    mon_en = 1; exp_slot = 0; exp_fr = 0;
    for (int f = 0; f < NFR - 1; f++) send_frame(f);

    // Misaligned marker exactly as slot 0's last bit arrives.
    for (int c = 0; c < 8; c++) drive(1'b1, c == 7, c);
    chk(exp_fr == NFR - 1 && exp_slot == 0, "R9 partial byte dropped, restart at slot 0",
        exp_slot, 0);
    send_frame(NFR - 1);
    for (int c = 0; c < 3; c++) drive(1'b0, 1'b0, c);
    mon_en = 0;
    chk(vcount == NFR * 32, "R10 one delivery per slot", vcount, NFR * 32);
    chk(exp_fr == NFR && exp_slot == 0, "R6 slot 31 delivered in next frame", exp_slot, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule